// File: doc/BRIEF.md
# SPI Master with Chip-Select Hold

This block is a single-slave SPI master that shifts fixed 16-bit characters. A producer (a processor or a DMA-style engine) pushes 32-bit command words over a valid/ready port. Each command word holds 16 bits of transmit data and a control field. The control field has two flags. The hold flag keeps the chip select asserted after the word, so that several words form one long frame. The delay flag forces the chip select to release for a fixed number of clocks after the word. For example, a 144-bit frame is sent as nine words: the first eight have hold set and the last has hold clear.

The serial clock idles low. Data goes out MSB first. MOSI changes on falling SCLK edges, and MISO is captured at the rising ones. The SCLK period is (prescale+1) module clocks. The high and low halves each last (prescale+1)/2 clocks, also when the ratio is odd: a counter on the rising clock edge is combined with a copy registered on the falling edge. Each received 16-bit word appears on a one-cycle valid output.

If hold is set and no further word arrives, the block parks with CS low and SCLK low. It resumes as soon as the next word is pushed. Words that are already waiting follow with no idle SCLK time.

Top module: `spi_hold_master`

## Requirements
- R1: A command word carries transmit data in bits 15:0, sent on MOSI MSB first. Bit 16 is the hold flag and bit 17 the delay flag. Bits 31:18 have no effect on the serial output.
- R2: While a word is shifted, SCLK makes exactly 16 cycles of (prescale+1) module clocks each, for prescale from 1 upward. Each cycle starts with its low half, and SCLK rests low between words.
- R3: The SCLK high time and the SCLK low time each equal (prescale+1)/2 module-clock periods, for both even and odd values of prescale+1.
- R4: MISO is sampled once per SCLK cycle, in its rising half. After the 16th cycle, rx_valid pulses for one clock, with the 16 sampled bits on rx_data, the first bit in bit 15.
- R5: If a word with hold set and delay clear completes while the next word is already offered, the next word's first SCLK cycle directly follows the last one (the rise-to-rise spacing stays prescale+1 clocks), and CS stays low.
- R6: If a word with hold set and delay clear completes and no word is offered, CS stays low and SCLK stays low for as long as needed, with busy and cmd_ready high. The next word continues the frame without a CS toggle.
- R7: A word with hold clear and delay clear raises CS on the same clock edge as its final SCLK falling edge. A word offered at that point is taken one clock later, so CS is high for exactly one clock.
- R8: After a word with the delay flag set, whatever its hold flag, CS goes high and the block takes no word for GAP_CYC clocks. The next frame opens GAP_CYC+1 clocks after CS rose.
- R9: During and right after reset: cs_n=1, sclk=0, busy=0, rx_valid=0 and cmd_ready=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prescale | input | PRESC_W | Divide value minus one (at least 1), held stable while busy |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word is taken on this clock when valid |
| cmd_data | input | 32 | Command word: data 15:0, hold bit 16, delay bit 17 |
| rx_valid | output | 1 | One-clock pulse: rx_data holds a received word |
| rx_data | output | 16 | Received word, MSB first on the wire |
| busy | output | 1 | High while shifting, parked or in the delay gap |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A serial slave model in the bench swaps words with the master, and edge timestamps measure the SCLK high, low and period times. Divide ratios 2 to 7 are swept, so even and odd ratios are both covered. Each ratio sends a three-word held frame, and junk in the ignored upper bits shows that the control decode does not reach them. Four patterns separate the frame-closing cases by the width of the CS high pulse: back-to-back words with hold clear, a parked hold, a hold that resumes, and a delay-flagged word.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
package spi_hold_pkg;
  localparam int CMD_W    = 32;
  localparam int CHAR_W   = 16;
  localparam int HOLD_POS = 16;
  localparam int DLY_POS  = 17;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_PARK  = 2'd2,
    ST_GAP   = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/spi_hold_div.sv
`timescale 1ns/1ps
// SCLK generator: low half first, then high half; odd ratios keep 50% duty
module spi_hold_div #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] div_m1,
  output logic          sclk,
  output logic          rise_stb,
  output logic          fall_stb
);
  localparam int CW = PW + 1;

  logic [CW-1:0] n_full, low_len;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          raw_q, raw_d, raw_fq;

  assign n_full  = {1'b0, div_m1} + CW'(1);
  assign low_len = n_full >> 1;

  // last clock of the low half: SCLK rises at the following edge
  assign rise_stb = run && ({1'b0, cnt_q} == (low_len - CW'(1)));
  // last clock of the period: SCLK falls at the following edge
  assign fall_stb = run && (cnt_q == div_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || fall_stb) cnt_d = '0;
    else                  cnt_d = cnt_q + PW'(1);
    raw_d = run && ({1'b0, cnt_d} >= low_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      raw_q <= raw_d;
    end
  end

  // half-cycle delayed copy trims the high half of odd ratios by half a clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) raw_fq <= 1'b0;
    else        raw_fq <= raw_q;
  end

  assign sclk = div_m1[0] ? raw_q : (raw_q & raw_fq);

  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !fall_stb);
  a_r2_high_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> raw_q);
endmodule

// File: rtl/spi_hold_shreg.sv
`timescale 1ns/1ps
// Single shift register: MSB drives MOSI, captured MISO enters at the LSB
module spi_hold_shreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rise_stb,
  input  logic          fall_stb,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_word
);
  logic [DW-1:0] sh_q, sh_d;
  logic          smp_q, smp_d;

  always_comb begin
    sh_d  = sh_q;
    smp_d = smp_q;
    if (rise_stb) smp_d = miso;
    if (load)          sh_d = load_data;
    else if (fall_stb) sh_d = {sh_q[DW-2:0], smp_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      smp_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      smp_q <= smp_d;
    end
  end

  assign mosi    = sh_q[DW-1];
  assign rx_word = {sh_q[DW-2:0], smp_q};
endmodule

// File: rtl/spi_hold_master.sv
`timescale 1ns/1ps
module spi_hold_master
  import spi_hold_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int GAP_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRESC_W-1:0]  prescale,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [CMD_W-1:0]    cmd_data,
  output logic                rx_valid,
  output logic [CHAR_W-1:0]   rx_data,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);
  localparam int BW = $clog2(CHAR_W);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  xfer_st_e          st_q, st_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic              hold_q, hold_d, dly_q, dly_d;
  logic              cs_n_q, cs_n_d;
  logic              rxv_q;
  logic [CHAR_W-1:0] rxd_q;
  logic              run, rise_stb, fall_stb, last_bit, word_done, accept, load;
  logic [CHAR_W-1:0] rx_word;
  logic              ctrl_unused;

  assign ctrl_unused = ^cmd_data[CMD_W-1:DLY_POS+1];

  spi_hold_div #(.PW(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n_i), .run(run), .div_m1(prescale),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  spi_hold_shreg #(.DW(CHAR_W)) u_sh (
    .clk(clk), .rst_n(rst_n_i), .load(load), .load_data(cmd_data[CHAR_W-1:0]),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  assign run       = (st_q == ST_SHIFT);
  assign last_bit  = (bit_q == BW'(CHAR_W-1));
  assign word_done = run && fall_stb && last_bit;
  assign cmd_ready = (st_q == ST_IDLE) || (st_q == ST_PARK) ||
                     (word_done && hold_q && !dly_q);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    gap_d  = gap_q;
    hold_d = hold_q;
    dly_d  = dly_q;
    load   = 1'b0;
    case (st_q)
      ST_IDLE, ST_PARK: begin
        if (accept) begin
          st_d = ST_SHIFT;
          load = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (fall_stb) begin
          if (last_bit) begin
            bit_d = '0;
            if (accept) load = 1'b1;
            else if (dly_q) begin
              st_d  = ST_GAP;
              gap_d = '0;
            end
            else if (hold_q) st_d = ST_PARK;
            else             st_d = ST_IDLE;
          end else begin
            bit_d = bit_q + BW'(1);
          end
        end
      end
      ST_GAP: begin
        if (gap_q == GW'(GAP_CYC-1)) st_d = ST_IDLE;
        else                         gap_d = gap_q + GW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    if (load) begin
      hold_d = cmd_data[HOLD_POS];
      dly_d  = cmd_data[DLY_POS];
    end
    cs_n_d = !((st_d == ST_SHIFT) || (st_d == ST_PARK));
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      gap_q  <= '0;
      hold_q <= 1'b0;
      dly_q  <= 1'b0;
      cs_n_q <= 1'b1;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      gap_q  <= gap_d;
      hold_q <= hold_d;
      dly_q  <= dly_d;
      cs_n_q <= cs_n_d;
      rxv_q  <= word_done;
      if (word_done) rxd_q <= rx_word;
    end
  end

  assign cs_n     = cs_n_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign busy     = (st_q != ST_IDLE);

  // R6: a parked frame keeps CS low and SCLK quiet
  a_r6_park_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q == ST_PARK) |-> (!cs_n_q && !sclk));
  // R7: CS only rises at the edge that ends a word
  a_r7_cs_rise_at_word_end: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(cs_n_q) |-> $past(word_done));
  // R8: during the delay gap CS is high and no word is taken
  a_r8_gap_closed: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q == ST_GAP) |-> (cs_n_q && !cmd_ready));
  // R4: received-word strobe is a single clock wide
  a_r4_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n_i)
    rxv_q |=> !rxv_q);
  // R2: a frame opens with SCLK in its idle level
  a_r2_open_low: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(cs_n_q) |-> !sclk);
endmodule

// File: tb/spi_hold_master_test.sv
`timescale 1ns/1ps
module spi_hold_master_test;
  localparam int PW  = 8;
  localparam int GAP = 4;
  localparam real TCK = 8.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] prescale = 8'd1;
  logic          cmd_valid = 1'b0;
  logic [31:0]   cmd_data = 32'd0;
  logic          cmd_ready, rx_valid, busy, sclk, mosi, miso, cs_n;
  logic [15:0]   rx_data;

  always #4 clk = ~clk;

  spi_hold_master #(.PRESC_W(PW), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  function automatic logic [15:0] slave_word(int k);
    return 16'hA5C3 ^ 16'(k * 4951);
  endfunction

  function automatic logic [31:0] mk(bit hold, bit dly, logic [15:0] d, logic [13:0] junk);
    return {junk, dly, hold, d};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_t(string req, string what, realtime act, realtime exp);
    longint a, e;
    a = longint'(act * 1000.0);
    e = longint'(exp * 1000.0);
    chk(a == e, req, what, a, e);
  endtask

  // ---------------- slave model ----------------
  logic [15:0] sl_tx = 16'hA5C3;
  logic [15:0] sl_rx = 16'h0000;
  int          sl_cnt = 0;
  int          sl_idx = 0;
  int          sl_n = 0;
  logic [15:0] sl_got [64];

  assign miso = sl_tx[15];

  always @(posedge sclk) begin
    logic [15:0] nx;
    nx = {sl_rx[14:0], mosi};
    sl_rx <= nx;
    if (sl_cnt == 15) begin
      sl_got[sl_n] <= nx;
      sl_n   <= sl_n + 1;
      sl_idx <= sl_idx + 1;
      sl_tx  <= slave_word(sl_idx + 1);
      sl_cnt <= 0;
    end else begin
      sl_cnt <= sl_cnt + 1;
    end
  end

  always @(negedge sclk) if (sl_cnt != 0) sl_tx <= sl_tx << 1;

  // ---------------- edge timing monitors ----------------
  int      frame_id = 0;
  int      rmon_id = -1;
  int      fmon_id = -1;
  int      fall_frame = -1;
  int      rises = 0;
  realtime t_rise = 0, t_fall = 0;
  realtime lo_min, lo_max, per_min, per_max, hi_min, hi_max;
  bit      had_rise = 0;

  always @(posedge sclk) begin
    realtime now;
    now = $realtime;
    if (rmon_id != frame_id) begin
      rmon_id = frame_id;
      lo_min = 1e9; lo_max = 0; per_min = 1e9; per_max = 0;
      rises = 0; had_rise = 0;
    end
    rises++;
    if (fall_frame == frame_id) begin
      if (now - t_fall < lo_min) lo_min = now - t_fall;
      if (now - t_fall > lo_max) lo_max = now - t_fall;
    end
    if (had_rise) begin
      if (now - t_rise < per_min) per_min = now - t_rise;
      if (now - t_rise > per_max) per_max = now - t_rise;
    end
    t_rise = now;
    had_rise = 1;
  end

  always @(negedge sclk) begin
    realtime now;
    now = $realtime;
    if (fmon_id != frame_id) begin
      fmon_id = frame_id;
      hi_min = 1e9; hi_max = 0;
    end
    if (now - t_rise < hi_min) hi_min = now - t_rise;
    if (now - t_rise > hi_max) hi_max = now - t_rise;
    t_fall = now;
    fall_frame = frame_id;
  end

  int      cs_rises = 0;
  realtime t_csr = 0, cs_hi = 0;
  always @(posedge cs_n) begin t_csr = $realtime; cs_rises++; end
  always @(negedge cs_n) cs_hi = $realtime - t_csr;

  int          rx_n = 0;
  logic [15:0] rx_got [64];
  always @(negedge clk) if (rx_valid) begin rx_got[rx_n] = rx_data; rx_n++; end

  // ---------------- stimulus ----------------
  int          push_n = 0;
  logic [15:0] pushed [64];

  task automatic push(logic [31:0] w);
    bit acc;
    cmd_data = w;
    cmd_valid = 1'b1;
    pushed[push_n] = w[15:0];
    push_n++;
    acc = 1'b0;
    while (!acc) begin
      acc = cmd_ready;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    int cr0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(cs_n == 1'b1, "R9", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0, "R9", "sclk in reset", sclk, 0);
    chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
    chk(rx_valid == 1'b0, "R9", "rx_valid in reset", rx_valid, 0);
    chk(cmd_ready == 1'b1, "R9", "cmd_ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R9", "idle after release", {cs_n, busy}, 2);

    // sweep of divide ratios 2..7, three-word held frame each
    for (int p = 1; p <= 6; p++) begin
      realtime half;
      half = (p + 1) * TCK / 2.0;
      frame_id++;
      prescale = 8'(p);
      cr0 = cs_rises;
      push(mk(1, 0, 16'(p * 4369) ^ 16'h3C5A, 14'h0000));
      push(mk(1, 0, 16'(p * 3855) ^ 16'h9B21, 14'h3FFF)); // R1 junk upper bits
      push(mk(0, 0, 16'(p * 257) ^ 16'h6E07, 14'h1555));
      wait_idle();
      chk(rises == 48, "R2", "sclk cycles in 3-word frame", rises, 48);
      chk_t("R5", "min rise-to-rise", per_min, 2.0 * half);
      chk_t("R5", "max rise-to-rise", per_max, 2.0 * half);
      chk_t("R3", "min high time", hi_min, half);
      chk_t("R3", "max high time", hi_max, half);
      chk_t("R3", "min low time", lo_min, half);
      chk_t("R3", "max low time", lo_max, half);
      chk(cs_rises - cr0 == 1, "R5", "cs rises in held frame", cs_rises - cr0, 1);
      chk_t("R7", "cs rise vs last sclk fall", t_csr - t_fall, 0.0);
    end

    // R7: two unheld words back to back
    prescale = 8'd2;
    push(mk(0, 0, 16'h8001, 14'h0));
    push(mk(0, 0, 16'h7FFE, 14'h0));
    wait_idle();
    chk_t("R7", "cs high between unheld words", cs_hi, TCK);

    // R6: parked hold, then resume
    prescale = 8'd3;
    cr0 = cs_rises;
    push(mk(1, 0, 16'hF00F, 14'h0));
    while (uut.rx_valid == 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(cs_n == 1'b0, "R6", "cs_n while parked", cs_n, 0);
    chk(sclk == 1'b0, "R6", "sclk while parked", sclk, 0);
    chk(busy == 1'b1, "R6", "busy while parked", busy, 1);
    chk(cmd_ready == 1'b1, "R6", "ready while parked", cmd_ready, 1);
    chk(cs_rises == cr0, "R6", "no cs toggle while parked", cs_rises - cr0, 0);
    push(mk(0, 0, 16'h0FF0, 14'h0));
    wait_idle();
    chk(cs_rises - cr0 == 1, "R6", "cs rises for parked frame", cs_rises - cr0, 1);

    // R8: delay flag forces a gap even with hold set
    prescale = 8'd2;
    cr0 = cs_rises;
    push(mk(1, 1, 16'hC33C, 14'h0));
    push(mk(0, 0, 16'h5AA5, 14'h0));
    wait_idle();
    chk_t("R8", "cs high across delay gap", cs_hi, (GAP + 1) * TCK);
    chk(cs_rises - cr0 == 2, "R8", "cs rises with delay word", cs_rises - cr0, 2);

    // R1 / R4: word contents both ways
    chk(sl_n == push_n, "R1", "words seen by slave", sl_n, push_n);
    chk(rx_n == push_n, "R4", "rx_valid pulses", rx_n, push_n);
    for (int k = 0; k < push_n; k++) begin
      chk(sl_got[k] == pushed[k], "R1", $sformatf("mosi word %0d", k), sl_got[k], pushed[k]);
      chk(rx_got[k] == slave_word(k), "R4", $sformatf("rx word %0d", k), rx_got[k], slave_word(k));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule